// File: doc/BRIEF.md
# Seven-Level Stepped Pulse Pattern Generator

This block produces the switch commands for a seven-level cascaded inverter made of three H-bridge modules in series. It does not compute a modulation pattern. It plays back a table that is prepared offline: one pulse per sampling slot, each with a programmable start offset and width in clock ticks. The half cycle is divided into six groups of slots. The voltage level rises from one to three and then falls back, so each slot drives exactly one level. The negative half cycle reuses the same table with the bridge polarity reversed.

The bridges below the level of the current slot stay at full output for the whole slot. The bridge at that level is pulsed. The bridges above it stay in the zero state. Levels therefore never overlap in time. Software writes the table through a plain write port. A shadow copy is taken only when an output cycle begins, so a table that changes while the block runs never produces a mixed cycle.

Top module: `step_pulse_gen`

## Requirements
- R1: While `rst` is high, every bridge nibble of `gate_out` is 4'b0101 (zero state, both lower switches on, both upper switches off). This also holds from the second clock edge after `en` is sampled low. Nibble bits [3:0] are {upper-left, lower-left, upper-right, lower-right}, and bridge b uses bits 4b+3:4b.
- R2: Each slot lasts exactly the number of ticks held in the slot-length register (address 0, bits 7:0, value at least 1).
- R3: With a repeat count R (address 1), a half cycle has 6R slots. Slots 0..R-1 are level 1, R..2R-1 level 2, 2R..4R-1 level 3, 4R..5R-1 level 2 and 5R..6R-1 level 1.
- R4: Table writes take effect only at the start of the next output cycle. A write made mid-cycle does not alter the cycle in progress.
- R5: In slot s, the bridge at that slot's level is active on ticks t with off ≤ t < off+wid, where the slot entry at address 2+s holds wid in bits 7:0 and off in bits 15:8. A pulse reaching past the slot end is clipped at the slot boundary.
- R6: Bridges below the slot level are active for the whole slot. Bridges above it are in the zero state.
- R7: An active bridge outputs 4'b1001 in the positive half cycle and 4'b0110 in the negative half cycle. The positive half comes first, and the same slot table is used in both halves.
- R8: No bridge ever has both switches of one leg on at the same time.
- R9: A repeat count of 0 behaves as 1, and a count above MAX_REPS behaves as MAX_REPS.
- R10: Writes to addresses above the last slot entry change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| en | input | 1 | run enable; low forces zero state and restarts the cycle |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | ADDR_W | register address |
| cfg_wdata | input | 2*TICK_W | register write data |
| gate_out | output | 12 | four switch commands per bridge, bridge 0 in the low nibble |

## Verification
When `en` is sampled high at edge E1, the table is captured and tick 0 of slot 0 starts. Its gate pattern appears after edge E2, and tick k of the run is visible after edge E(k+2). The bench samples on the falling edge after each rising edge and steps through every tick in that order. A mid-run write is committed at the next rising edge, and the bench expects it only in the following output cycle. After `en` drops, the zero state is checked after the second rising edge.

// File: rtl/slpg_pkg.sv
package slpg_pkg;
  localparam int BRIDGES = 3;
  typedef logic [3:0] gate_t;
  // bits: {upper-left, lower-left, upper-right, lower-right}
  localparam gate_t GATE_ZERO = 4'b0101;
  localparam gate_t GATE_POS  = 4'b1001;
  localparam gate_t GATE_NEG  = 4'b0110;
  typedef logic [1:0] level_t;
endpackage

// File: rtl/slpg_regs.sv
module slpg_regs #(
  parameter int TICK_W   = 8,
  parameter int MAX_REPS = 2,
  parameter int ADDR_W   = 5,
  localparam int SLOTS   = 6 * MAX_REPS,
  localparam int REP_W   = $clog2(MAX_REPS + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [2*TICK_W-1:0]           wdata,
  input  logic                          load,
  output logic [TICK_W-1:0]             sh_len,
  output logic [REP_W-1:0]              sh_reps,
  output logic [SLOTS-1:0][TICK_W-1:0]  sh_wid,
  output logic [SLOTS-1:0][TICK_W-1:0]  sh_off
);
  logic [TICK_W-1:0]            len_q, reps_q;
  logic [SLOTS-1:0][TICK_W-1:0] wid_q, off_q;
  logic [REP_W-1:0]             reps_cl;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= TICK_W'(1);
      reps_q <= TICK_W'(1);
      wid_q  <= '0;
      off_q  <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(0)) len_q  <= wdata[TICK_W-1:0];
      if (addr == ADDR_W'(1)) reps_q <= wdata[TICK_W-1:0];
      for (int i = 0; i < SLOTS; i++) begin
        if (addr == ADDR_W'(i + 2)) begin
          wid_q[i] <= wdata[TICK_W-1:0];
          off_q[i] <= wdata[2*TICK_W-1:TICK_W];
        end
      end
    end
  end

  always_comb begin
    if (reps_q == '0)                      reps_cl = REP_W'(1);
    else if (reps_q > TICK_W'(MAX_REPS))   reps_cl = REP_W'(MAX_REPS);
    else                                   reps_cl = reps_q[REP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_len  <= TICK_W'(1);
      sh_reps <= REP_W'(1);
      sh_wid  <= '0;
      sh_off  <= '0;
    end else if (load) begin
      sh_len  <= len_q;
      sh_reps <= reps_cl;
      sh_wid  <= wid_q;
      sh_off  <= off_q;
    end
  end

  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(sh_len) && $stable(sh_reps) && $stable(sh_wid) && $stable(sh_off)));

  assert_reps_range_R9: assert property (@(posedge clk) disable iff (rst)
    (sh_reps >= REP_W'(1)) && (sh_reps <= REP_W'(MAX_REPS)));
endmodule

// File: rtl/slpg_seq.sv
module slpg_seq #(
  parameter int TICK_W   = 8,
  parameter int MAX_REPS = 2,
  localparam int REP_W   = $clog2(MAX_REPS + 1),
  localparam int SLOT_W  = $clog2(6 * MAX_REPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [TICK_W-1:0] sh_len,
  input  logic [REP_W-1:0]  sh_reps,
  output logic              load,
  output logic              run,
  output logic [TICK_W-1:0] tick,
  output logic [SLOT_W-1:0] slot,
  output logic              neg
);
  logic              last_tick, last_slot;
  logic [SLOT_W-1:0] slot_top;

  always_comb begin
    slot_top  = SLOT_W'(6 * int'(sh_reps) - 1);
    last_tick = (tick == sh_len - TICK_W'(1));
    last_slot = (slot == slot_top);
    load      = en && (!run || (last_tick && last_slot && neg));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run  <= 1'b0;
      tick <= '0;
      slot <= '0;
      neg  <= 1'b0;
    end else if (load) begin
      run  <= 1'b1;
      tick <= '0;
      slot <= '0;
      neg  <= 1'b0;
    end else if (last_tick) begin
      tick <= '0;
      if (last_slot) begin
        slot <= '0;
        neg  <= ~neg;
      end else begin
        slot <= slot + SLOT_W'(1);
      end
    end else begin
      tick <= tick + TICK_W'(1);
    end
  end

  assert_tick_bound_R2: assert property (@(posedge clk) disable iff (rst)
    run |-> (tick < sh_len));

  assert_half_flip_R7: assert property (@(posedge clk) disable iff (rst)
    (en && run && last_tick && last_slot && !neg) |=> neg);
endmodule

// File: rtl/slpg_bridge.sv
module slpg_bridge
  import slpg_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   run,
  input  logic   neg,
  input  level_t level,
  input  logic   pulse,
  output gate_t  gate
);
  localparam level_t MY_LVL = level_t'(IDX + 1);
  logic active;

  always_comb active = (level > MY_LVL) || ((level == MY_LVL) && pulse);

  always_ff @(posedge clk) begin
    if (rst || !run)  gate <= GATE_ZERO;
    else if (active)  gate <= neg ? GATE_NEG : GATE_POS;
    else              gate <= GATE_ZERO;
  end

  assert_leg_safe_R8: assert property (@(posedge clk)
    !(gate[3] && gate[2]) && !(gate[1] && gate[0]));

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (gate == GATE_ZERO));
endmodule

// File: rtl/step_pulse_gen.sv
module step_pulse_gen
  import slpg_pkg::*;
#(
  parameter int TICK_W   = 8,
  parameter int MAX_REPS = 2,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [2*TICK_W-1:0] cfg_wdata,
  output logic [4*BRIDGES-1:0] gate_out
);
  localparam int SLOTS  = 6 * MAX_REPS;
  localparam int REP_W  = $clog2(MAX_REPS + 1);
  localparam int SLOT_W = $clog2(SLOTS);

  logic                         load, run, neg, pulse;
  logic [TICK_W-1:0]            sh_len, tick, wid, off;
  logic [REP_W-1:0]             sh_reps;
  logic [SLOTS-1:0][TICK_W-1:0] sh_wid, sh_off;
  logic [SLOT_W-1:0]            slot;
  logic [SLOT_W:0]              slot_x, b1, b2, b4, b5;
  level_t                       level;

  slpg_regs #(.TICK_W(TICK_W), .MAX_REPS(MAX_REPS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(load), .sh_len(sh_len), .sh_reps(sh_reps), .sh_wid(sh_wid), .sh_off(sh_off)
  );

  slpg_seq #(.TICK_W(TICK_W), .MAX_REPS(MAX_REPS)) u_seq (
    .clk(clk), .rst(rst), .en(en), .sh_len(sh_len), .sh_reps(sh_reps),
    .load(load), .run(run), .tick(tick), .slot(slot), .neg(neg)
  );

  // level staircase 1,2,3,3,2,1 with each step R slots long
  always_comb begin
    slot_x = {1'b0, slot};
    b1 = (SLOT_W+1)'(1 * int'(sh_reps));
    b2 = (SLOT_W+1)'(2 * int'(sh_reps));
    b4 = (SLOT_W+1)'(4 * int'(sh_reps));
    b5 = (SLOT_W+1)'(5 * int'(sh_reps));
    if      (slot_x < b1) level = 2'd1;
    else if (slot_x < b2) level = 2'd2;
    else if (slot_x < b4) level = 2'd3;
    else if (slot_x < b5) level = 2'd2;
    else                  level = 2'd1;
  end

  always_comb begin
    wid   = sh_wid[slot];
    off   = sh_off[slot];
    pulse = (tick >= off) && ({1'b0, tick} < ({1'b0, off} + {1'b0, wid}));
  end

  for (genvar b = 0; b < BRIDGES; b++) begin : g_br
    slpg_bridge #(.IDX(b)) u_br (
      .clk(clk), .rst(rst), .run(run), .neg(neg), .level(level),
      .pulse(pulse), .gate(gate_out[4*b +: 4])
    );
  end

  for (genvar b = 1; b < BRIDGES; b++) begin : g_chk
    assert_stacked_R6: assert property (@(posedge clk) disable iff (rst)
      (gate_out[4*b +: 4] != GATE_ZERO) |-> (gate_out[4*(b-1) +: 4] == gate_out[4*b +: 4]));
  end
endmodule

// File: tb/step_pulse_gen_bench.sv
`timescale 1ns/1ps
module step_pulse_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [11:0] gate_out;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  int m_len, m_reps;
  int m_w[12];
  int m_o[12];
  int c_len, c_reps;
  int c_w[12];
  int c_o[12];

  always #2.5 clk = ~clk;

  step_pulse_gen u_step_pulse_gen (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gate_out(gate_out)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: gate_out=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void mirror(input int a, input int d);
    if (a == 0) m_len = d & 255;
    else if (a == 1) m_reps = d & 255;
    else if (a >= 2 && a < 14) begin
      m_w[a-2] = d & 255;
      m_o[a-2] = (d >> 8) & 255;
    end
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
    mirror(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_slot(input int s, input int o, input int w);
    wr(2 + s, (o << 8) | w);
  endtask

  function automatic logic [11:0] model(input int s, input int h, input int t);
    int p, lvl;
    bit pul;
    logic [11:0] g;
    p = 6 * c_reps;
    lvl = (s < 3 * c_reps) ? (s / c_reps + 1) : ((p - 1 - s) / c_reps + 1);
    pul = (t >= c_o[s]) && (t < c_o[s] + c_w[s]);
    for (int b = 0; b < 3; b++) begin
      if (b < lvl - 1 || (b == lvl - 1 && pul)) g[4*b +: 4] = h ? 4'b0110 : 4'b1001;
      else g[4*b +: 4] = 4'b0101;
    end
    return g;
  endfunction

  task automatic start_run();
    @(negedge clk);
    en = 1'b1;
    @(posedge clk);
  endtask

  task automatic stop_run(input string tag);
    @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(tag, gate_out, 12'h555);
  endtask

  // steps every tick of ncyc output cycles; optional single write at sample index inj
  task automatic run_cycles(input string tag, input int ncyc, input int inj,
                            input int ia, input int id);
    int glob = 0;
    for (int c = 0; c < ncyc; c++) begin
      c_len = m_len;
      c_reps = (m_reps == 0) ? 1 : ((m_reps > 2) ? 2 : m_reps);
      for (int i = 0; i < 12; i++) begin c_w[i] = m_w[i]; c_o[i] = m_o[i]; end
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < 6 * c_reps; s++)
          for (int t = 0; t < c_len; t++) begin
            @(posedge clk);
            @(negedge clk);
            if (cfg_we) cfg_we = 1'b0;
            check(tag, gate_out, model(s, h, t));
            checks++;
            for (int b = 0; b < 3; b++)
              if ((gate_out[4*b+3] && gate_out[4*b+2]) || (gate_out[4*b+1] && gate_out[4*b])) begin
                bad++;
                $display("FAIL R8: bridge %0d gate=%b expected no shorted leg", b, gate_out[4*b +: 4]);
              end
            if (glob == inj) begin
              cfg_we = 1'b1; cfg_addr = 5'(ia); cfg_wdata = 16'(id);
              mirror(ia, id);
            end
            glob++;
          end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", gate_out, 12'h555);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", gate_out, 12'h555);
    m_len = 1; m_reps = 1;
    for (int i = 0; i < 12; i++) begin m_w[i] = 0; m_o[i] = 0; end
  endtask

  task automatic t_basic();
    wr(0, 8); wr(1, 1);
    wr_slot(0, 1, 3); wr_slot(1, 0, 5); wr_slot(2, 2, 4);
    wr_slot(3, 3, 2); wr_slot(4, 0, 8); wr_slot(5, 6, 1);
    start_run();
    run_cycles("R2 R3 R5 R6 R7 basic", 2, -1, 0, 0);
    stop_run("R1 disable after basic");
  endtask

  task automatic t_double();
    wr(0, 5); wr(1, 2);
    for (int i = 0; i < 12; i++) wr_slot(i, i % 3, (i + 1) % 5);
    start_run();
    run_cycles("R3 twelve slots", 1, -1, 0, 0);
    stop_run("R1 disable after twelve");
  endtask

  task automatic t_clip();
    wr(0, 6); wr(1, 1);
    wr_slot(0, 4, 5); wr_slot(1, 5, 3); wr_slot(2, 0, 6);
    wr_slot(3, 3, 7); wr_slot(4, 2, 2); wr_slot(5, 0, 0);
    start_run();
    run_cycles("R5 clip at slot end", 1, -1, 0, 0);
    stop_run("R1 disable after clip");
  endtask

  task automatic t_midwrite();
    wr(0, 4); wr(1, 1);
    for (int i = 0; i < 6; i++) wr_slot(i, 1, 1);
    start_run();
    run_cycles("R4 write held to next cycle", 2, 10, 4, (0 << 8) | 3);
    stop_run("R1 disable after midwrite");
  endtask

  task automatic t_clamp();
    wr(0, 3); wr(1, 0);
    for (int i = 0; i < 12; i++) wr_slot(i, i % 2, 2);
    start_run();
    run_cycles("R9 zero repeat acts as one", 1, -1, 0, 0);
    stop_run("R1 disable after clamp0");
    wr(1, 7);
    start_run();
    run_cycles("R9 large repeat acts as max", 1, -1, 0, 0);
    stop_run("R1 disable after clamp7");
  endtask

  task automatic t_unmapped();
    wr(0, 4); wr(1, 1);
    for (int i = 0; i < 6; i++) wr_slot(i, 0, 2);
    start_run();
    run_cycles("R10 unmapped write ignored", 2, 5, 20, 16'h0104);
    stop_run("R1 disable after unmapped");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_double();
    t_clip();
    t_midwrite();
    t_clamp();
    t_unmapped();
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule